// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration header of one peripheral function as 64 registers of 32 bits each. Software reaches it through one access port. The port takes a register index, a byte offset inside the register and an access size of 1, 2 or 4 bytes. Write data is little-endian: byte 0 of the write data lands in the lane chosen by the offset. Every write passes through a writable-bit mask that is fixed per register, so identity fields, type bits and read-only halves keep their values whatever software writes.

The identity fields are set at elaboration time: vendor and device numbers, class triple, revision, subsystem numbers, header kind (endpoint or bridge), the multifunction flag and the interrupt pin. The size and kind of each base address register (BAR) are set the same way. From the region size the block derives each BAR's writable mask. Writing all ones to a BAR and reading it back therefore reports the region size, the way enumeration software expects. In bridge mode the block applies the bridge header's window registers, their reset values and their masks.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, register 0 reads {device ID, vendor ID} (device ID in bits 31:16) and register 2 reads {class, subclass, programming interface, revision} from bit 31 down. Register 0 never changes when written.
- R2: A read at an index of 64 or above returns 0xFFFFFFFF. A write there changes no register.
- R3: A write sets a register to (old AND NOT m) OR (new AND m), where m is that register's writable mask. Register 1 has mask 0x0000FFFF and register 3 has mask 0x000000FF.
- R4: The size input is encoded 1, 2 or 4 for bytes. A 1-byte write is legal at any offset, a 2-byte write only at offset 0 or 2, and a 4-byte write only at offset 0. Any other size or offset leaves every register unchanged.
- R5: Write data is little-endian. Byte k of the write data goes to byte lane offset+k of the register.
- R6: Register 3 holds the header kind in bits 22:16 (0 for endpoint, 1 for bridge) and the multifunction flag in bit 23.
- R7: In endpoint mode, register 11 reads {subsystem ID, subsystem vendor ID} and is read-only.
- R8: In bridge mode, registers 7, 8 and 9 reset to 0x000000F0, 0x0000FFF0 and 0x0001FFF1. The writable masks are 0x00FFFFFF for register 6, 0xF9000000 for register 7, 0xFFF0FFF0 for registers 8 and 9, and all ones for registers 10 and 11. BAR settings for BAR2 and above are ignored in this mode.
- R9: BAR n sits at register 4+n. Its mask is NOT(size−1), and its low type bits (0x0 for 32-bit memory, 0x1 for I/O, 0x4 for 64-bit memory) stay read-only. The register above a 64-bit BAR has mask NOT((size−1)>>32).
- R10: The expansion ROM register (12) has mask NOT(size−1) with bit 0 (the enable) also writable.
- R11: Register 15 holds the 1-based interrupt pin, read-only, in bits 15:8 and a writable interrupt line in bits 7:0. In bridge mode bits 31:16 are writable as well.
- R12: A write takes effect at the clock edge. A read in the next cycle returns the merged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the current access |
| accIdx | input | IDX_W | Register index (dword) |
| accOff | input | 2 | Byte offset within the register |
| accSize | input | 3 | Access size in bytes (1, 2 or 4) |
| wrData | input | 32 | Write data, least significant byte first |
| rdData | output | 32 | Read data for accIdx, combinational |

## Verification
A wrong mask or a wrong reset constant shows up in the first read of the affected register after reset or after one write. The read path is combinational, so a corrupted merge appears on rdData in the cycle right after the faulty edge. A lane decode error shows as bytes that move or fail to change next to the lane that was written. The random traffic compares every access against a model built from the requirement values, so such an error surfaces within a few hundred cycles.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int ROWS    = 64;
  localparam int ROW_W   = $clog2(ROWS);
  localparam int DW      = 32;
  localparam int LANES   = DW / 8;
  localparam int NUM_BAR = 6;
  localparam int BAR_ROW0 = 4;
  localparam int ROM_ROW  = 12;
  localparam int IRQ_ROW  = 15;

  localparam logic [1:0] KIND_NONE  = 2'd0;
  localparam logic [1:0] KIND_MEM32 = 2'd1;
  localparam logic [1:0] KIND_IO    = 2'd2;
  localparam logic [1:0] KIND_MEM64 = 2'd3;

  typedef struct packed {
    logic             wrGo;
    logic [ROW_W-1:0] row;
    logic [LANES-1:0] lanes;
    logic [DW-1:0]    data;
    logic             rdHit;
  } cfgStrobe_t;

  function automatic logic [63:0] sizeMinusOne(input logic [5:0] lg);
    return (64'd1 << lg) - 64'd1;
  endfunction

  function automatic logic [31:0] bridgeMask(input int r);
    case (r)
      6:       return 32'h00FF_FFFF;
      7:       return 32'hF900_0000;
      8, 9:    return 32'hFFF0_FFF0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] rowMask(
      input int r, input logic bridge, input logic [2*NUM_BAR-1:0] kind,
      input logic [6*NUM_BAR-1:0] lg, input logic [5:0] romLg);
    logic [63:0] sm;
    int b;
    b = r - BAR_ROW0;
    if (r == 1) return 32'h0000_FFFF;
    if (r == 3) return 32'h0000_00FF;
    if (r == IRQ_ROW) return bridge ? 32'hFFFF_00FF : 32'h0000_00FF;
    if (r == ROM_ROW) begin
      sm = sizeMinusOne(romLg);
      return (romLg != 6'd0) ? (~sm[31:0] | 32'h1) : 32'h0;
    end
    if (r == 10 || r == 11) return bridge ? 32'hFFFF_FFFF : 32'h0;
    if (b >= 0 && b < NUM_BAR) begin
      if (bridge && b >= 2) return bridgeMask(r);
      if (b > 0 && kind[2*(b-1) +: 2] == KIND_MEM64) begin
        sm = sizeMinusOne(lg[6*(b-1) +: 6]);
        return ~sm[63:32];
      end
      if (kind[2*b +: 2] != KIND_NONE) begin
        sm = sizeMinusOne(lg[6*b +: 6]);
        return ~sm[31:0];
      end
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] rowReset(
      input int r, input logic bridge, input logic multi,
      input logic [2*NUM_BAR-1:0] kind, input logic [31:0] ident,
      input logic [31:0] classWord, input logic [31:0] subsysWord,
      input logic [7:0] pin);
    int b;
    b = r - BAR_ROW0;
    case (r)
      0:       return ident;
      2:       return classWord;
      3:       return {8'h00, multi, 7'(bridge), 16'h0000};
      11:      return bridge ? 32'h0 : subsysWord;
      IRQ_ROW: return {16'h0000, pin, 8'h00};
      default: ;
    endcase
    if (bridge && r == 7) return 32'h0000_00F0;
    if (bridge && r == 8) return 32'h0000_FFF0;
    if (bridge && r == 9) return 32'h0001_FFF1;
    if (b >= 0 && b < NUM_BAR && !(bridge && b >= 2)) begin
      if (b > 0 && kind[2*(b-1) +: 2] == KIND_MEM64) return 32'h0;
      case (kind[2*b +: 2])
        KIND_IO:    return 32'h1;
        KIND_MEM64: return 32'h4;
        default:    return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction
endpackage

// File: rtl/cfg_space_dec.sv
module cfg_space_dec
  import cfg_space_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] accIdx,
  input  logic [1:0]       accOff,
  input  logic [2:0]       accSize,
  input  logic [DW-1:0]    wrData,
  output cfgStrobe_t       strobe
);
  logic [LANES-1:0] laneSel;
  logic             inRange;

  always_comb begin
    laneSel = '0;
    case (accSize)
      3'd1: laneSel = LANES'(1) << accOff;
      3'd2: begin
        if (accOff == 2'd0) laneSel = 4'b0011;
        else if (accOff == 2'd2) laneSel = 4'b1100;
      end
      3'd4: if (accOff == 2'd0) laneSel = 4'b1111;
      default: laneSel = '0;
    endcase
  end

  assign inRange = (accIdx < IDX_W'(ROWS));

  always_comb begin
    strobe.wrGo  = wrEn && inRange && (laneSel != '0);
    strobe.row   = accIdx[ROW_W-1:0];
    strobe.lanes = laneSel;
    strobe.data  = wrData << {accOff, 3'b000};
    strobe.rdHit = inRange;
  end
endmodule

// File: rtl/cfg_space_store.sv
module cfg_space_store
  import cfg_space_pkg::*;
#(
  parameter logic              BRIDGE     = 1'b0,
  parameter logic              MULTIFN    = 1'b0,
  parameter logic [31:0]       IDENT      = 32'h0,
  parameter logic [31:0]       CLASS_WORD = 32'h0,
  parameter logic [31:0]       SUBSYS     = 32'h0,
  parameter logic [7:0]        IRQ_PIN    = 8'h1,
  parameter logic [2*NUM_BAR-1:0] BAR_KIND = '0,
  parameter logic [6*NUM_BAR-1:0] BAR_LOG2 = '0,
  parameter logic [5:0]        ROM_LOG2   = 6'd0
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobe_t  strobe,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] rows [ROWS];
  logic [DW-1:0] laneBits;

  always_comb begin
    for (int k = 0; k < LANES; k++) laneBits[8*k +: 8] = {8{strobe.lanes[k]}};
  end

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    localparam logic [DW-1:0] MASK = rowMask(r, BRIDGE, BAR_KIND, BAR_LOG2, ROM_LOG2);
    localparam logic [DW-1:0] RST  = rowReset(r, BRIDGE, MULTIFN, BAR_KIND, IDENT,
                                              CLASS_WORD, SUBSYS, IRQ_PIN);
    logic [DW-1:0] bitEn;
    assign bitEn = laneBits & MASK;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rows[r] <= RST;
      else if (strobe.wrGo && strobe.row == ROW_W'(r))
        rows[r] <= (rows[r] & ~bitEn) | (strobe.data & bitEn);
    end
  end

  assign rdData = strobe.rdHit ? rows[strobe.row] : '1;
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfg_space_pkg::*;
#(
  parameter int          IDX_W       = 8,
  parameter logic [15:0] VENDOR_ID   = 16'h1234,
  parameter logic [15:0] DEVICE_ID   = 16'h5678,
  parameter logic [7:0]  CLASS_CODE  = 8'h04,
  parameter logic [7:0]  SUB_CLASS   = 8'h01,
  parameter logic [7:0]  PROG_IF     = 8'h5A,
  parameter logic [7:0]  REVISION    = 8'h03,
  parameter logic [15:0] SUBSYS_VID  = 16'hABCD,
  parameter logic [15:0] SUBSYS_ID   = 16'h2468,
  parameter logic        BRIDGE      = 1'b0,
  parameter logic        MULTIFN     = 1'b0,
  parameter logic [7:0]  IRQ_PIN     = 8'h01,
  parameter logic [2*NUM_BAR-1:0] BAR_KIND = {2'd0, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1},
  parameter logic [6*NUM_BAR-1:0] BAR_LOG2 = {6'd0, 6'd0, 6'd0, 6'd36, 6'd5, 6'd12},
  parameter logic [5:0]  ROM_LOG2    = 6'd11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] accIdx,
  input  logic [1:0]       accOff,
  input  logic [2:0]       accSize,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData
);
  cfgStrobe_t strobe;

  cfg_space_dec #(.IDX_W(IDX_W)) uDec (
    .wrEn(wrEn), .accIdx(accIdx), .accOff(accOff), .accSize(accSize),
    .wrData(wrData), .strobe(strobe)
  );

  cfg_space_store #(
    .BRIDGE(BRIDGE), .MULTIFN(MULTIFN),
    .IDENT({DEVICE_ID, VENDOR_ID}),
    .CLASS_WORD({CLASS_CODE, SUB_CLASS, PROG_IF, REVISION}),
    .SUBSYS({SUBSYS_ID, SUBSYS_VID}),
    .IRQ_PIN(IRQ_PIN), .BAR_KIND(BAR_KIND), .BAR_LOG2(BAR_LOG2),
    .ROM_LOG2(ROM_LOG2)
  ) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData)
  );
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
  parameter int          IDX_W     = 8,
  parameter logic [15:0] VENDOR_ID = 16'h0,
  parameter logic [15:0] DEVICE_ID = 16'h0,
  parameter logic        BRIDGE    = 1'b0,
  parameter logic        MULTIFN   = 1'b0,
  parameter logic [7:0]  IRQ_PIN   = 8'h0
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [IDX_W-1:0] accIdx,
  input logic [1:0]       accOff,
  input logic [2:0]       accSize,
  input logic [31:0]      wrData,
  input logic [31:0]      rdData
);
  logic badSize;
  assign badSize = !(accSize == 3'd1 || accSize == 3'd2 || accSize == 3'd4);

  AST_OOR_ONES: assert property (@(posedge clk) disable iff (!rstN)
    accIdx >= IDX_W'(64) |-> rdData == 32'hFFFF_FFFF); // R2
  AST_IDENT_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    accIdx == '0 |-> rdData == {DEVICE_ID, VENDOR_ID}); // R1
  AST_HDR_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    accIdx == IDX_W'(3) |-> rdData[23:16] == {MULTIFN, 7'(BRIDGE)}); // R6
  AST_PIN_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    accIdx == IDX_W'(15) |-> rdData[15:8] == IRQ_PIN); // R11
  AST_BAD_SIZE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && badSize) |=> ($stable(accIdx) -> $stable(rdData))); // R4
  AST_CMD_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && accSize == 3'd4 && accOff == 2'd0 && accIdx == IDX_W'(1))
      |=> (accIdx == IDX_W'(1) -> rdData[15:0] == $past(wrData[15:0]))); // R12
endmodule

bind cfg_space_regs cfg_space_chk #(
  .IDX_W(IDX_W), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
  .BRIDGE(BRIDGE), .MULTIFN(MULTIFN), .IRQ_PIN(IRQ_PIN)
) uChk (.*);

// File: tb/cfg_space_regs_test.sv
module cfg_space_regs_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] accIdx = '0;
  logic [1:0] accOff = '0;
  logic [2:0] accSize = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdBr;
  int total = 0;
  int bad = 0;
  logic [31:0] mdl [64];

  always #5 clk = ~clk;

  cfg_space_regs uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .accIdx(accIdx),
    .accOff(accOff), .accSize(accSize), .wrData(wrData), .rdData(rdData));

  cfg_space_regs #(.BRIDGE(1'b1), .MULTIFN(1'b1)) uutBr (.clk(clk), .rstN(rstN),
    .wrEn(wrEn), .accIdx(accIdx), .accOff(accOff), .accSize(accSize),
    .wrData(wrData), .rdData(rdBr));

  function automatic logic [31:0] expMask(int i);
    case (i)
      1:  return 32'h0000_FFFF;
      3:  return 32'h0000_00FF;
      4:  return 32'hFFFF_F000;
      5:  return 32'hFFFF_FFE0;
      7:  return 32'hFFFF_FFF0;
      12: return 32'hFFFF_F801;
      15: return 32'h0000_00FF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] expRst(int i);
    case (i)
      0:  return 32'h5678_1234;
      2:  return 32'h0401_5A03;
      5:  return 32'h0000_0001;
      6:  return 32'h0000_0004;
      11: return 32'h2468_ABCD;
      15: return 32'h0000_0100;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] expLanes(logic [2:0] sz, logic [1:0] off);
    if (sz == 3'd1) return 4'b0001 << off;
    if (sz == 3'd2 && off == 2'd0) return 4'b0011;
    if (sz == 3'd2 && off == 2'd2) return 4'b1100;
    if (sz == 3'd4 && off == 2'd0) return 4'b1111;
    return 4'b0000;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic doWrite(int idx, logic [2:0] sz, logic [1:0] off, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; accIdx = 8'(idx); accSize = sz; accOff = off; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readAt(int idx);
    accIdx = 8'(idx);
    #1;
  endtask

  task automatic mdlWrite(int idx, logic [2:0] sz, logic [1:0] off, logic [31:0] d);
    logic [3:0] ln;
    logic [31:0] en, sh;
    ln = expLanes(sz, off);
    sh = d << (8 * off);
    for (int k = 0; k < 4; k++) en[8*k +: 8] = {8{ln[k]}};
    en = en & expMask(idx);
    if (idx < 64) mdl[idx] = (mdl[idx] & ~en) | (sh & en);
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mdl[i] = expRst(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    readAt(0);  chk("R1 ident reset", rdData, 32'h5678_1234);
    readAt(2);  chk("R1 class reset", rdData, 32'h0401_5A03);
    readAt(3);  chk("R6 endpoint header", rdData, 32'h0000_0000);
    readAt(11); chk("R7 subsystem", rdData, 32'h2468_ABCD);
    readAt(15); chk("R11 pin reset", rdData, 32'h0000_0100);
    readAt(70); chk("R2 out of range", rdData, 32'hFFFF_FFFF);
    readAt(3);  chk("R6 bridge header multifn", rdBr, 32'h0081_0000);
    readAt(7);  chk("R8 bridge r7 reset", rdBr, 32'h0000_00F0);
    readAt(8);  chk("R8 bridge r8 reset", rdBr, 32'h0000_FFF0);
    readAt(9);  chk("R8 bridge r9 reset", rdBr, 32'h0001_FFF1);

    doWrite(0, 3'd4, 2'd0, 32'hDEAD_BEEF); mdlWrite(0, 3'd4, 2'd0, 32'hDEAD_BEEF);
    readAt(0); chk("R1 ident read-only", rdData, 32'h5678_1234);
    doWrite(11, 3'd4, 2'd0, 32'hFFFF_FFFF);
    readAt(11); chk("R7 subsystem read-only", rdData, 32'h2468_ABCD);
    chk("R8 bridge r11 writable", rdBr, 32'hFFFF_FFFF);
    doWrite(1, 3'd4, 2'd0, 32'hFFFF_FFFF); mdlWrite(1, 3'd4, 2'd0, 32'hFFFF_FFFF);
    readAt(1); chk("R3 command half", rdData, 32'h0000_FFFF);

    foreach (mdl[i]) ;
    doWrite(4, 3'd4, 2'd0, 32'hFFFF_FFFF); mdlWrite(4, 3'd4, 2'd0, 32'hFFFF_FFFF);
    readAt(4); chk("R9 mem32 sizing", rdData, 32'hFFFF_F000);
    doWrite(5, 3'd4, 2'd0, 32'hFFFF_FFFF); mdlWrite(5, 3'd4, 2'd0, 32'hFFFF_FFFF);
    readAt(5); chk("R9 io sizing", rdData, 32'hFFFF_FFE1);
    doWrite(6, 3'd4, 2'd0, 32'hFFFF_FFFF); mdlWrite(6, 3'd4, 2'd0, 32'hFFFF_FFFF);
    readAt(6); chk("R9 mem64 low sizing", rdData, 32'h0000_0004);
    chk("R8 bridge r6", rdBr, 32'h00FF_FFFF);
    doWrite(7, 3'd4, 2'd0, 32'hFFFF_FFFF); mdlWrite(7, 3'd4, 2'd0, 32'hFFFF_FFFF);
    readAt(7); chk("R9 mem64 high sizing", rdData, 32'hFFFF_FFF0);
    chk("R8 bridge r7 mask", rdBr, 32'hF900_00F0);
    doWrite(8, 3'd4, 2'd0, 32'h0);
    readAt(8); chk("R8 bridge r8 cleared", rdBr, 32'h0);
    doWrite(12, 3'd4, 2'd0, 32'hFFFF_FFFF); mdlWrite(12, 3'd4, 2'd0, 32'hFFFF_FFFF);
    readAt(12); chk("R10 rom sizing with enable", rdData, 32'hFFFF_F801);
    doWrite(12, 3'd1, 2'd0, 32'h0000_0000); mdlWrite(12, 3'd1, 2'd0, 32'h0);
    readAt(12); chk("R10 rom enable cleared", rdData, 32'hFFFF_F800);
    doWrite(15, 3'd4, 2'd0, 32'hFFFF_FFFF); mdlWrite(15, 3'd4, 2'd0, 32'hFFFF_FFFF);
    readAt(15); chk("R11 line writable", rdData, 32'h0000_01FF);
    chk("R11 bridge control", rdBr, 32'hFFFF_01FF);

    doWrite(1, 3'd2, 2'd1, 32'h0000_1111);
    readAt(1); chk("R4 misaligned half ignored", rdData, mdl[1]);
    doWrite(1, 3'd2, 2'd0, 32'h0000_A55A); mdlWrite(1, 3'd2, 2'd0, 32'h0000_A55A);
    readAt(1); chk("R5 half lanes", rdData, 32'h0000_A55A);
    doWrite(1, 3'd1, 2'd1, 32'h0000_003C); mdlWrite(1, 3'd1, 2'd1, 32'h0000_003C);
    readAt(1); chk("R5 byte lane one", rdData, 32'h0000_3C5A);
    doWrite(3, 3'd3, 2'd0, 32'h0000_0077);
    readAt(3); chk("R4 size three ignored", rdData, mdl[3]);
    doWrite(3, 3'd1, 2'd0, 32'h0000_0077); mdlWrite(3, 3'd1, 2'd0, 32'h0000_0077);
    readAt(3); chk("R3 cacheline byte", rdData, 32'h0000_0077);
    doWrite(66, 3'd4, 2'd0, 32'h0);
    readAt(66); chk("R2 out of range write", rdData, 32'hFFFF_FFFF);

    for (int n = 0; n < 400; n++) begin
      int idx;
      logic [2:0] sz;
      logic [1:0] off;
      logic [31:0] d;
      idx = int'($urandom % 70);
      case ($urandom % 5)
        0: sz = 3'd0;
        1: sz = 3'd1;
        2: sz = 3'd2;
        3: sz = 3'd3;
        default: sz = 3'd4;
      endcase
      off = 2'($urandom);
      d = $urandom;
      doWrite(idx, sz, off, d);
      mdlWrite(idx, sz, off, d);
      readAt(idx);
      chk("R12 random merge", rdData, (idx < 64) ? mdl[idx] : 32'hFFFF_FFFF);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule